// File: doc/BRIEF.md
# I2C Register Target with Row-Bounded Write Burst

This block is an I2C target that serves a 256-byte register space. It watches SCL and SDA, recognises START and STOP conditions, and shifts bytes most significant bit first. The 7-bit device address has a fixed upper nibble of binary 1010. Its lower three bits come from strap inputs, so eight of these targets can share one bus. The bus SDA pin is open drain, and the block models it as an output enable: when the enable is high, the line is pulled low.

A write transaction carries the device address, then a pointer byte, then any number of data bytes. Each data byte lands at the pointer. The pointer then advances only within its aligned 8-byte row and wraps back to the start of that row. A read transaction returns the byte at the pointer and keeps returning bytes while the controller acknowledges them. In a read, the pointer advances over the full 8-bit range. A busy input makes the target refuse its own address, so a controller can poll until the target is ready.

Top module: `i2c_row_target`

## Requirements
- R1: While and after reset, with no transaction, `sda_oe` is 0 (line released).
- R2: An address byte whose upper 7 bits equal 1010 followed by `addr_pins[2:0]` is acknowledged: `sda_oe` is 1 throughout the ninth SCL pulse.
- R3: An address byte that does not match is not acknowledged. All following bytes, including one equal to the matching address, get no acknowledge and cause no drive until the next START.
- R4: While `busy` is 1, a matching address byte is not acknowledged. The transaction is then ignored until the next START.
- R5: In a write (address bit 0 = 0), the next byte sets the pointer. Each byte after it is stored at the pointer, and every such byte is acknowledged.
- R6: After each stored data byte, pointer bits [2:0] increment modulo 8 and bits [7:3] stay. Three bytes written from BEh land at BEh, BFh and B8h.
- R7: In a read (address bit 0 = 1), bytes are returned MSB first from the pointer. The pointer moves to pointer+1 modulo 256 after each byte the controller acknowledges, so reads cross row boundaries and FFh is followed by 00h.
- R8: When the controller does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R9: `sda_oe` changes only while SCL is low.
- R10: A START at any point, including in the middle of a byte, restarts address reception with an empty bit count.
- R11: After a STOP, the block drives nothing and ignores clocked bytes until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_pins | input | 3 | Strap value for the low three address bits |
| busy | input | 1 | When high, the device address is refused |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain model) |

## Verification
The bench builds the block with the default 8-bit pointer and 3-bit row field, which gives a 256-byte space with 8-byte rows. These are the values that make the BEh-to-B8h wrap, the BFh-to-C0h read crossing and the FFh-to-00h pointer wrap reachable with a few bus transactions. The straps are set to 101, so the write address byte is AAh and the read address byte is ABh. This leaves 1010000 free as a mismatching address. The SCL quarter period is ten system clocks, which leaves room for the two-flop synchronizer delay before each edge the block acts on.

// File: rtl/i2c_row_pkg.sv
package i2c_row_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RX   = 3'd1,
    S_ACK  = 3'd2,
    S_TX   = 3'd3,
    S_RACK = 3'd4
  } tgt_state_t;

  typedef enum logic [1:0] {
    K_DEV  = 2'd0,
    K_PTR  = 2'd1,
    K_DATA = 2'd2
  } byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_row_mem.sv
module i2c_row_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end
endmodule

// File: rtl/i2c_row_ctrl.sv
module i2c_row_ctrl
  import i2c_row_pkg::*;
#(
  parameter int         AW     = 8,
  parameter int         RW     = 3,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    addr_pins,
  input  logic          busy,
  input  logic [7:0]    rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic [AW-1:0] ptr,
  output tgt_state_t    state,
  output logic          sda_oe
);
  localparam logic [RW-1:0] ROW_ONE = RW'(1);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  byte_kind_t kind;
  logic [7:0] sh;
  logic [7:0] tx;
  logic [3:0] cnt;
  logic       rd_mode;
  logic       nack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      kind    <= K_DEV;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rd_mode <= 1'b0;
      nack_q  <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state  <= S_RX;
        kind   <= K_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: sda_oe <= 1'b0;
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              unique case (kind)
                K_DEV: begin
                  if (sh[7:1] == {DEV_ID, addr_pins} && !busy) begin
                    rd_mode <= sh[0];
                    sda_oe  <= 1'b1;
                    state   <= S_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                K_PTR: begin
                  ptr    <= sh;
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end
                default: begin
                  we     <= 1'b1;
                  waddr  <= ptr;
                  wdata  <= sh;
                  ptr    <= {ptr[AW-1:RW], ptr[RW-1:0] + ROW_ONE};
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_DEV && rd_mode) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                kind   <= (kind == K_DEV) ? K_PTR : K_DATA;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= S_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
              if (!sda_s) begin
                ptr <= ptr + PTR_ONE;
              end
            end else if (scl_fall) begin
              if (!nack_q) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
                cnt    <= '0;
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_row_target.sv
module i2c_row_target
  import i2c_row_pkg::*;
#(
  parameter int         AW          = 8,
  parameter int         RW          = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_pins,
  input  logic       busy,
  output logic       sda_oe
);
  logic          scl_rise;
  logic          scl_fall;
  logic          sda_s;
  logic          start_det;
  logic          stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] ptr;
  tgt_state_t    state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_row_ctrl #(.AW(AW), .RW(RW), .DEV_ID(DEV_ID)) ctrl_i (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .addr_pins(addr_pins), .busy(busy), .rdata(mem_rdata),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata), .ptr(ptr),
    .state(state), .sda_oe(sda_oe)
  );

  i2c_row_mem #(.AW(AW), .DW(8)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/i2c_row_chk.sv
module i2c_row_chk
  import i2c_row_pkg::*;
#(
  parameter int AW = 8,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          start_det,
  input logic          stop_det,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input tgt_state_t    state
);
  // R1
  rst_release_chk: assert property (@(posedge clk) rst |=> !sda_oe);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> state == S_IDLE);

  // R10
  start_rx_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> state == S_RX);

  // R6
  row_keep_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> ptr[AW-1:RW] == $past(ptr[AW-1:RW]));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_IDLE && $past(state) == S_IDLE |-> !sda_oe);
endmodule

bind i2c_row_target i2c_row_chk #(.AW(AW), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .mem_we(mem_we),
  .ptr(ptr), .state(state)
);

// File: tb/i2c_row_target_tb_top.sv
`timescale 1ns/1ps
module i2c_row_target_tb_top;
  localparam int         Q    = 100;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] DWR  = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] DRD  = {4'b1010, PINS, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic busy = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   total = 0;
  int   bad = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_row_target dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pins(PINS), .busy(busy), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; #(Q); m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); b = sda_line; #(Q); m_scl = 1'b0; #(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b0; #(Q); m_scl = 1'b0; #(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b1; #(4*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic nk;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nk);
    acked = !nk;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!give_ack);
  endtask

  task automatic wr3(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                     input logic [7:0] d2, input int n);
    logic ak;
    bus_start();
    send_byte(DWR, ak); chk("R2 write addr ack", 8'(ak), 8'h01);
    send_byte(a, ak);   chk("R5 ptr ack", 8'(ak), 8'h01);
    send_byte(d0, ak);  chk("R5 data ack", 8'(ak), 8'h01);
    if (n > 1) send_byte(d1, ak);
    if (n > 2) send_byte(d2, ak);
    bus_stop();
  endtask

  task automatic set_ptr_read(input logic [7:0] a);
    logic ak;
    bus_start();
    send_byte(DWR, ak);
    send_byte(a, ak);
    bus_start();
    send_byte(DRD, ak); chk("R2 read addr ack", 8'(ak), 8'h01);
  endtask

  task automatic t_reset();
    chk("R1 released after reset", 8'(sda_oe), 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    wr3(8'h10, 8'h11, 8'h22, 8'h33, 3);
    set_ptr_read(8'h10);
    recv_byte(1'b1, d); chk("R5 R7 rd 10", d, 8'h11);
    recv_byte(1'b1, d); chk("R7 rd 11", d, 8'h22);
    recv_byte(1'b0, d); chk("R7 rd 12", d, 8'h33);
    bus_stop();
  endtask

  task automatic t_row_wrap();
    logic [7:0] d;
    wr3(8'hB8, 8'h00, 8'h00, 8'h00, 1);
    wr3(8'hBE, 8'h11, 8'h22, 8'h33, 3);
    set_ptr_read(8'hB8);
    recv_byte(1'b0, d); chk("R6 B8 holds third byte", d, 8'h33);
    bus_stop();
    set_ptr_read(8'hBE);
    recv_byte(1'b1, d); chk("R6 BE", d, 8'h11);
    recv_byte(1'b0, d); chk("R6 BF", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_read_cross();
    logic [7:0] d;
    wr3(8'hC0, 8'h5A, 8'h00, 8'h00, 1);
    wr3(8'hFF, 8'hE1, 8'h00, 8'h00, 1);
    wr3(8'h00, 8'h0E, 8'h00, 8'h00, 1);
    set_ptr_read(8'hBF);
    recv_byte(1'b1, d); chk("R7 BF", d, 8'h22);
    recv_byte(1'b0, d); chk("R7 crosses row to C0", d, 8'h5A);
    bus_stop();
    set_ptr_read(8'hFF);
    recv_byte(1'b1, d); chk("R7 FF", d, 8'hE1);
    recv_byte(1'b0, d); chk("R7 wraps to 00", d, 8'h0E);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic ak;
    bus_start();
    send_byte(8'hA0, ak); chk("R3 wrong addr nack", 8'(ak), 8'h00);
    send_byte(DWR, ak);   chk("R3 ignored until START", 8'(ak), 8'h00);
    send_byte(8'h10, ak); chk("R3 still ignored", 8'(ak), 8'h00);
    bus_stop();
  endtask

  task automatic t_busy();
    logic ak;
    logic [7:0] d;
    busy = 1'b1;
    bus_start();
    send_byte(DWR, ak);   chk("R4 busy nack", 8'(ak), 8'h00);
    send_byte(8'h10, ak); chk("R4 rest ignored", 8'(ak), 8'h00);
    bus_stop();
    busy = 1'b0;
    set_ptr_read(8'h10);
    recv_byte(1'b0, d); chk("R4 data kept", d, 8'h11);
    bus_stop();
  endtask

  task automatic t_nack_end();
    logic [7:0] d;
    set_ptr_read(8'h10);
    recv_byte(1'b0, d); chk("R8 last byte", d, 8'h11);
    recv_byte(1'b0, d); chk("R8 released after nack", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_restart();
    logic ak;
    logic [7:0] d;
    bus_start();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    send_byte(DWR, ak);   chk("R10 addr ack after mid-byte START", 8'(ak), 8'h01);
    send_byte(8'h40, ak);
    send_byte(8'h5C, ak);
    bus_stop();
    set_ptr_read(8'h40);
    recv_byte(1'b0, d); chk("R10 write landed", d, 8'h5C);
    bus_stop();
  endtask

  task automatic t_stop();
    logic ak;
    bus_start();
    send_byte(DWR, ak);
    bus_stop();
    send_byte(DWR, ak);   chk("R11 no ack after STOP", 8'(ak), 8'h00);
    send_byte(8'h20, ak); chk("R11 still idle", 8'(ak), 8'h00);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_row_wrap();
    t_read_cross();
    t_mismatch();
    t_busy();
    t_nack_end();
    t_restart();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule